// File: doc/BRIEF.md
# Activity-Driven System Clock Rate Controller

This block picks the rate of the general system clock. It produces a clock-enable pulse train, not a clock. In high-rate mode the enable is asserted on every cycle. In low-rate mode the enable pulses once per divided period, and the divided period is 2, 4 or 8 input cycles.

Three activity conditions can raise the rate:
- a pending interrupt, which has its own wake enable;
- the core's power-management bit being clear, meaning the core is in normal operation;
- a busy or requesting communications coprocessor, which has its own wake enable.

When no activity condition holds and the auto-return enable is set, the block drops back to the low rate. A change of rate is applied only where a divided period ends, so no partial pulse reaches the clocked logic.

Three states make up the controller:
- FAST: full rate.
- SLOW: divided rate, no wake seen.
- SLOW_WAKING: divided rate, wake latched and waiting for the end of the period.

The transitions are:
- FAST to SLOW when the block is idle and auto-return is set.
- SLOW to FAST when a wake arrives on the last cycle of a period.
- SLOW to SLOW_WAKING when a wake arrives on any other cycle.
- SLOW_WAKING to FAST on the last cycle of the period.

Top module: `sysclk_rate_ctrl`

## Requirements
- R1: After reset the block is in FAST: `high_mode` is 1 and `clk_en` is 1.
- R2: While `high_mode` is 1, `clk_en` is 1 on every cycle.
- R3: In FAST, with no wake condition and `auto_low_en`=1, the next cycle is in SLOW (`high_mode`=0). Counting that cycle as period cycle 0, `clk_en` is 1 only on cycle N-1 of each period of N cycles.
- R4: With `auto_low_en`=0 the block stays in FAST even when there is no wake condition.
- R5: `irq_pending`=1 wakes the block only when `irq_wake_en`=1. With `irq_wake_en`=0 it has no effect.
- R6: `core_doze`=0 wakes the block whatever the two enables are set to.
- R7: `cp_busy`=1 wakes the block only when `cp_wake_en`=1. With `cp_wake_en`=0 it has no effect.
- R8: `low_div_sel` codes 0, 1, 2 and 3 give N = 2, 4, 8 and 8.
- R9: A wake seen in SLOW takes effect only at the end of the period. `high_mode` rises on the cycle after the `clk_en` pulse. A wake that goes away before then still completes the rise.
- R10: The value of `low_div_sel` is captured when SLOW is entered and again at each period end. A change made mid-period applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pending | input | 1 | Interrupt pending |
| core_doze | input | 1 | Core power-management bit (1 = power saving, 0 = normal operation) |
| cp_busy | input | 1 | Coprocessor request pending or not idle |
| irq_wake_en | input | 1 | Lets `irq_pending` wake the block |
| cp_wake_en | input | 1 | Lets `cp_busy` wake the block |
| auto_low_en | input | 1 | Allows return to the low rate when idle |
| low_div_sel | input | 2 | Low-rate divider code |
| clk_en | output | 1 | Clock-enable pulse train |
| high_mode | output | 1 | 1 when running at the high rate |

## Verification
Both outputs decode registered state, so every result appears one clock edge after the input that causes it.

A drop to SLOW shows on the first sample after the edge. The first enable pulse follows N-1 samples later. A wake shows as `high_mode` on the sample after the edge that ends the current period, so up to N samples after the stimulus.

The bench drives inputs on falling edges and samples before driving. It indexes every check by the cycle count since entering SLOW, so each expected value is pinned to one exact period cycle.

// File: rtl/rate_ctrl_pkg.sv
package rate_ctrl_pkg;
    parameter int DIV_LOG2_MAX = 3;
    localparam int CNT_W = DIV_LOG2_MAX;

    typedef enum logic [1:0] {
        ST_FAST        = 2'd0,
        ST_SLOW        = 2'd1,
        ST_SLOW_WAKING = 2'd2
    } rate_state_t;

    // period length minus one for a divider code; codes past the top clamp
    function automatic logic [CNT_W-1:0] period_last(input logic [1:0] code);
        int shift;
        shift = int'(code) + 1;
        if (shift > DIV_LOG2_MAX) shift = DIV_LOG2_MAX;
        return CNT_W'((1 << shift) - 1);
    endfunction
endpackage

// File: rtl/wake_detect.sv
module wake_detect (
    input  logic irq_pending,
    input  logic core_doze,
    input  logic cp_busy,
    input  logic irq_wake_en,
    input  logic cp_wake_en,
    output logic wake
);
    logic irq_term, core_term, cp_term;

    always_comb begin
        irq_term  = irq_pending & irq_wake_en;
        core_term = ~core_doze;
        cp_term   = cp_busy & cp_wake_en;
        wake      = irq_term | core_term | cp_term;
    end
endmodule

// File: rtl/period_counter.sv
module period_counter
    import rate_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       at_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            last_q <= period_last(2'd0);
        end else if (!run) begin
            cnt    <= '0;
            last_q <= period_last(div_sel);
        end else if (cnt == last_q) begin
            cnt    <= '0;
            last_q <= period_last(div_sel);
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        at_end = run && (cnt == last_q);
    end
endmodule

// File: rtl/rate_fsm.sv
module rate_fsm
    import rate_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic auto_low_en,
    input  logic at_end,
    output logic slow_run,
    output logic clk_en,
    output logic high_mode
);
    rate_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAST: begin
                if (!wake && auto_low_en) state_d = ST_SLOW;
            end
            ST_SLOW: begin
                if (wake && at_end)  state_d = ST_FAST;
                else if (wake)       state_d = ST_SLOW_WAKING;
            end
            ST_SLOW_WAKING: begin
                if (at_end) state_d = ST_FAST;
            end
            default: state_d = ST_FAST;
        endcase
    end

    always_comb begin
        slow_run  = 1'b0;
        clk_en    = 1'b1;
        high_mode = 1'b1;
        unique case (state_q)
            ST_FAST: begin
                slow_run  = 1'b0;
                clk_en    = 1'b1;
                high_mode = 1'b1;
            end
            ST_SLOW, ST_SLOW_WAKING: begin
                slow_run  = 1'b1;
                clk_en    = at_end;
                high_mode = 1'b0;
            end
            default: begin
                slow_run  = 1'b0;
                clk_en    = 1'b1;
                high_mode = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sysclk_rate_ctrl.sv
module sysclk_rate_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_pending,
    input  logic       core_doze,
    input  logic       cp_busy,
    input  logic       irq_wake_en,
    input  logic       cp_wake_en,
    input  logic       auto_low_en,
    input  logic [1:0] low_div_sel,
    output logic       clk_en,
    output logic       high_mode
);
    logic wake;
    logic at_end;
    logic slow_run;

    wake_detect u_wake (
        .irq_pending (irq_pending),
        .core_doze   (core_doze),
        .cp_busy     (cp_busy),
        .irq_wake_en (irq_wake_en),
        .cp_wake_en  (cp_wake_en),
        .wake        (wake)
    );

    period_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (slow_run),
        .div_sel (low_div_sel),
        .at_end  (at_end)
    );

    rate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake        (wake),
        .auto_low_en (auto_low_en),
        .at_end      (at_end),
        .slow_run    (slow_run),
        .clk_en      (clk_en),
        .high_mode   (high_mode)
    );
endmodule

// File: rtl/rate_ctrl_checks.sv
module rate_ctrl_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_pending,
    input logic       core_doze,
    input logic       cp_busy,
    input logic       irq_wake_en,
    input logic       cp_wake_en,
    input logic       auto_low_en,
    input logic [1:0] low_div_sel,
    input logic       clk_en,
    input logic       high_mode
);
    // R2: full rate whenever in high mode
    p_fast_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        high_mode |-> clk_en);

    // R3: low-rate pulses never come back to back
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!high_mode && clk_en) |=> (high_mode || !clk_en));

    // R9: rate rises only after a period-end pulse
    p_rise_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!high_mode && !clk_en) |=> !high_mode);

    // R4: no return to low rate while auto-return is off
    p_hold_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (high_mode && !auto_low_en) |=> high_mode);

    // R6: normal core operation keeps the high rate
    p_core_keeps_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (high_mode && !core_doze) |=> high_mode);

    // R5 and R7: enabled wake sources keep the high rate
    p_src_keeps_fast_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (high_mode && ((irq_pending && irq_wake_en) || (cp_busy && cp_wake_en))) |=> high_mode);
endmodule

bind sysclk_rate_ctrl rate_ctrl_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pending (irq_pending),
    .core_doze   (core_doze),
    .cp_busy     (cp_busy),
    .irq_wake_en (irq_wake_en),
    .cp_wake_en  (cp_wake_en),
    .auto_low_en (auto_low_en),
    .low_div_sel (low_div_sel),
    .clk_en      (clk_en),
    .high_mode   (high_mode)
);

// File: tb/sim_sysclk_rate_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_rate_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pending = 1'b0;
    logic       core_doze = 1'b0;
    logic       cp_busy = 1'b0;
    logic       irq_wake_en = 1'b0;
    logic       cp_wake_en = 1'b0;
    logic       auto_low_en = 1'b0;
    logic [1:0] low_div_sel = 2'd0;
    logic       clk_en;
    logic       high_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysclk_rate_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pending (irq_pending),
        .core_doze   (core_doze),
        .cp_busy     (cp_busy),
        .irq_wake_en (irq_wake_en),
        .cp_wake_en  (cp_wake_en),
        .auto_low_en (auto_low_en),
        .low_div_sel (low_div_sel),
        .clk_en      (clk_en),
        .high_mode   (high_mode)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic to_fast();
        irq_pending = 0; cp_busy = 0; irq_wake_en = 0; cp_wake_en = 0;
        auto_low_en = 0; core_doze = 0;
        repeat (10) step();
    endtask

    // leaves caller at period cycle 0 of SLOW
    task automatic go_slow(input logic [1:0] sel);
        core_doze = 1; irq_pending = 0; cp_busy = 0; auto_low_en = 1;
        low_div_sel = sel;
        step();
        chk(high_mode, 1'b0, "R3 enter slow");
    endtask

    task automatic check_periods(input int n, input string tag);
        for (int j = 0; j < 2*n; j++) begin
            chk(clk_en, (j % n) == n-1, tag);
            chk(high_mode, 1'b0, tag);
            step();
        end
    endtask

    task automatic t_reset();
        chk(high_mode, 1'b1, "R1 high_mode after reset");
        chk(clk_en, 1'b1, "R1 clk_en after reset");
        for (int i = 0; i < 4; i++) begin
            step();
            chk(clk_en, 1'b1, "R2 full rate");
        end
    endtask

    task automatic t_auto_off();
        to_fast();
        core_doze = 1; auto_low_en = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            chk(high_mode, 1'b1, "R4 stays fast");
            chk(clk_en, 1'b1, "R4 R2 enable");
        end
    endtask

    task automatic t_dividers();
        to_fast(); go_slow(2'd0); check_periods(2, "R8 code0 div2");
        to_fast(); go_slow(2'd1); check_periods(4, "R8 code1 div4");
        to_fast(); go_slow(2'd2); check_periods(8, "R8 code2 div8");
        to_fast(); go_slow(2'd3); check_periods(8, "R8 code3 div8");
    endtask

    task automatic t_irq();
        to_fast(); go_slow(2'd2);
        irq_pending = 1; irq_wake_en = 0;
        check_periods(8, "R5 masked irq no effect");
        irq_wake_en = 1;
        // now at cycle 0; wake seen, rise only after period end
        step();
        for (int j = 1; j < 8; j++) begin
            chk(high_mode, 1'b0, "R9 wait for period end");
            if (j == 2) irq_pending = 0; // request latched anyway
            if (j < 8) chk(clk_en, j == 7, "R9 pulse at end");
            step();
        end
        chk(high_mode, 1'b1, "R5 R9 irq wake");
        chk(clk_en, 1'b1, "R2 after wake");
    endtask

    task automatic t_cp();
        to_fast(); go_slow(2'd1);
        cp_busy = 1; cp_wake_en = 0;
        check_periods(4, "R7 masked cp no effect");
        cp_wake_en = 1;
        for (int j = 0; j < 4; j++) step();
        chk(high_mode, 1'b1, "R7 cp wake");
    endtask

    task automatic t_core();
        to_fast(); go_slow(2'd0);
        step(); // cycle 1 = period end
        chk(clk_en, 1'b1, "R9 end pulse");
        core_doze = 0;
        step();
        chk(high_mode, 1'b1, "R6 core wake at end");
    endtask

    task automatic t_sel_change();
        to_fast(); go_slow(2'd2);
        step(); step(); // cycle 2
        low_div_sel = 2'd0;
        for (int j = 2; j < 7; j++) begin
            chk(clk_en, 1'b0, "R10 old length held");
            step();
        end
        chk(clk_en, 1'b1, "R10 end of old period");
        step();
        chk(clk_en, 1'b0, "R10 new period cycle0");
        step();
        chk(clk_en, 1'b1, "R10 new period div2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_auto_off();
        t_dividers();
        t_irq();
        t_cp();
        t_core();
        t_sel_change();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule